// File: doc/BRIEF.md
# Battery-Backed SRAM Enable Controller

This block is the digital core of a supervisor that turns an ordinary static RAM into nonvolatile storage. External comparators report the state of the supply and of up to two backup cells as digital flags. The block uses these flags to gate the memory's active-low chip-enable, to pick the cell that backs the memory, and to choose whether the memory rail is fed from the supply, from a battery, or from neither.

While the supply is healthy, the chip-enable passes straight through. When the supply sags, writes are blocked, but only once the access already in flight has ended. On every power-up the block waits out a recovery delay before passing enables again. If the active cell was weak at that moment, the block quietly drops the second memory access. Software then sees a written value fail to read back, which is how it learns the battery is low. A newly assembled unit begins in a sealed state: no backup current is drawn until the supply has come up once and then fallen below the battery.

Top module: `nvsram_supervisor`

## Requirements
- R1: With the supply in tolerance and recovery finished, `mem_ce_n` equals `host_ce_n` combinationally.
- R2: If the supply leaves tolerance while `mem_ce_n` is low, `mem_ce_n` stays low until `host_ce_n` goes high. From then on it is held high, whatever `host_ce_n` does, for as long as the supply is bad.
- R3: `tol_wide`=0 treats `vdd_ok_5` as supply-good. `tol_wide`=1 treats `vdd_ok_10` as supply-good.
- R4: If the selected cell is bad when the supply becomes good, then `status[0]`=1 and the second access after recovery (between the first and second rising edges of `host_ce_n`) keeps `mem_ce_n` high. `status[0]` changes only at a power-up evaluation.
- R5: `bat_sel` is 0 for cell A and 1 for cell B. With B present, a cell that is good is chosen over a cell that is bad. When both cells are good, or both are bad, the higher cell is chosen (`a_ge_b`).
- R6: While `b_grounded`=1, cell A is selected. A grounded B therefore never causes a low-battery indication.
- R7: After reset the block is sealed. In that state `mem_ce_n`=0, `rail_src`=2'b10 (off) and `status[1]`=1. Sealing ends when the supply is first seen good and `vdd_gt_bat` is later seen low. Once ended, it never returns.
- R8: After the supply becomes good, `mem_ce_n` stays high for at least `REC_CYCLES` clock cycles.
- R9: When not sealed, `rail_src` is 2'b00 (supply) while `vdd_gt_bat`=1 and 2'b01 (battery) otherwise. `status[2]` is 1 exactly when the rail is on battery.
- R10: The access count saturates at two, so the third access and every later one pass through even after a low-battery power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset (cells attached) |
| host_ce_n | input | 1 | Chip-enable from the host, active low |
| vdd_ok_5 | input | 1 | Supply above trip point, narrow tolerance |
| vdd_ok_10 | input | 1 | Supply above trip point, wide tolerance |
| tol_wide | input | 1 | Tolerance select |
| bat_a_ok | input | 1 | Cell A above minimum |
| bat_b_ok | input | 1 | Cell B above minimum |
| b_grounded | input | 1 | Cell B input tied to ground |
| a_ge_b | input | 1 | Cell A voltage at least cell B |
| vdd_gt_bat | input | 1 | Supply above battery voltage |
| mem_ce_n | output | 1 | Gated chip-enable to the memory, active low |
| bat_sel | output | 1 | Selected backup cell |
| rail_src | output | 2 | Memory rail source: 00 supply, 01 battery, 10 off |
| status | output | 3 | {on battery, sealed, battery low at power-up} |

## Verification
The bench sets `REC_CYCLES` to 6 and keeps two synchronizer stages. This makes the whole recovery window observable within a few cycles of a power-up, so the bench can probe both sides of it: an enable that is still blocked after six cycles and an enable that passes a few cycles later. The short window also allows several complete power cycles in one run. The bench therefore covers a weak-cell power-up with the blocked second access, the redundant-cell and grounded-cell evaluations, and a brown-out that arrives in the middle of an access.

// File: rtl/nvs_pkg.sv
// Package nvs_pkg
// Shared encodings for the supervisor: rail source codes, control states
// and positions of the synchronized flag vector.
package nvs_pkg;

    typedef enum logic [1:0] {
        RAIL_VDD = 2'b00,
        RAIL_BAT = 2'b01,
        RAIL_OFF = 2'b10
    } rail_t;

    typedef enum logic [1:0] {
        CT_DOWN    = 2'b00,
        CT_RECOVER = 2'b01,
        CT_ACTIVE  = 2'b10,
        CT_DRAIN   = 2'b11
    } ctrl_t;

    localparam int FLAG_W   = 8;
    localparam int F_OK5    = 0;
    localparam int F_OK10   = 1;
    localparam int F_TOL    = 2;
    localparam int F_A_OK   = 3;
    localparam int F_B_OK   = 4;
    localparam int F_B_GND  = 5;
    localparam int F_A_GE_B = 6;
    localparam int F_GT_BAT = 7;

endpackage

// File: rtl/nvs_sync.sv
// Module nvs_sync
// Multi-stage synchronizer for a vector of slow status flags.
// Assumes each bit is independent; no coherency across bits is promised.
module nvs_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // first stage captures the asynchronous flags
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // later stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nvs_bat_sel.sv
// Module nvs_bat_sel
// Picks the backup cell from the synchronized comparator flags and reports
// whether the chosen cell is below its minimum. Pure combinational.
// Assumes a grounded cell B means a single-cell build on input A.
module nvs_bat_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic a_ok,
    input  logic b_ok,
    input  logic b_gnd,
    input  logic a_ge_b,
    output logic sel_b,
    output logic sel_bad
);
    // choose a good cell over a bad one, else the higher cell
    always_comb begin
        if (b_gnd)            sel_b = 1'b0;
        else if (a_ok != b_ok) sel_b = b_ok;
        else                  sel_b = !a_ge_b;
    end

    // weakness of the chosen cell
    assign sel_bad = sel_b ? !b_ok : !a_ok;

    p_gnd_b_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_gnd |-> (!sel_b && (sel_bad == !a_ok)));

    p_good_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_gnd && (a_ok || b_ok)) |-> !sel_bad);
endmodule

// File: rtl/nvs_seal.sv
// Module nvs_seal
// Freshness seal: set by reset (cells attached), ends once the supply has
// been seen good and then falls below the battery. Never re-enters.
module nvs_seal (
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_ok,
    input  logic vdd_gt_bat,
    output logic sealed,
    output logic dark
);
    logic tripped;

    // record the first good supply and release the seal afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sealed  <= 1'b1;
            tripped <= 1'b0;
        end else begin
            if (vdd_ok) tripped <= 1'b1;
            if (sealed && tripped && !vdd_gt_bat) sealed <= 1'b0;
        end
    end

    // sealed and never powered: rail and enable are pulled low
    assign dark = sealed && !tripped;

    p_seal_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sealed |=> !sealed);

    p_seal_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sealed) |-> $past(tripped && !vdd_gt_bat));
endmodule

// File: rtl/nvs_ctrl.sv
// Module nvs_ctrl
// Enable gating state machine: recovery wait, pass-through, cycle-complete
// write protection and the low-battery second-access block.
// Assumes host_ce_n is synchronous to clk; its pass-through is combinational.
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int REC_CYCLES = 4_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_ok,
    input  logic host_ce_n,
    input  logic sel_bad,
    output logic ce_gate_n,
    output logic bat_low
);
    localparam int CW = $clog2(REC_CYCLES + 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_CYCLES - 1);

    ctrl_t          st;
    logic [CW-1:0]  rec_cnt;
    logic [1:0]     acc_cnt;
    logic           ce_prev;
    logic           ce_rise;
    logic           blk;

    assign ce_rise = !ce_prev && host_ce_n;
    assign blk     = bat_low && (acc_cnt == 2'd1);

    // output gating per state
    always_comb begin
        unique case (st)
            CT_ACTIVE: ce_gate_n = host_ce_n | blk;
            CT_DRAIN:  ce_gate_n = host_ce_n;
            default:   ce_gate_n = 1'b1;
        endcase
    end

    // previous enable level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ce_prev <= 1'b1;
        else        ce_prev <= host_ce_n;
    end

    // state, recovery counter, access counter and power-up battery latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= CT_DOWN;
            rec_cnt <= '0;
            acc_cnt <= 2'd0;
            bat_low <= 1'b0;
        end else begin
            unique case (st)
                CT_DOWN: begin
                    if (vdd_ok) begin
                        st      <= CT_RECOVER;
                        rec_cnt <= '0;
                        bat_low <= sel_bad;
                    end
                end
                CT_RECOVER: begin
                    if (!vdd_ok) begin
                        st <= CT_DOWN;
                    end else if (rec_cnt == REC_LAST) begin
                        st      <= CT_ACTIVE;
                        acc_cnt <= 2'd0;
                    end else begin
                        rec_cnt <= rec_cnt + 1'b1;
                    end
                end
                CT_ACTIVE: begin
                    if (!vdd_ok)
                        st <= ce_gate_n ? CT_DOWN : CT_DRAIN;
                    else if (ce_rise && acc_cnt != 2'd2)
                        acc_cnt <= acc_cnt + 1'b1;
                end
                CT_DRAIN: begin
                    if (host_ce_n) st <= CT_DOWN;
                end
            endcase
        end
    end

    p_acc_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cnt != 2'd3);

    p_drain_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CT_DRAIN && host_ce_n) |=> (st == CT_DOWN));

    p_batlow_eval_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_low != $past(bat_low)) |-> $past(st == CT_DOWN && vdd_ok));

    p_recover_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CT_ACTIVE && $past(st) == CT_RECOVER) |-> $past(rec_cnt) == REC_LAST);

    p_down_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CT_DOWN || st == CT_RECOVER) |-> ce_gate_n);
endmodule

// File: rtl/nvsram_supervisor.sv
// Module nvsram_supervisor
// Top of the nonvolatile SRAM supervisor: synchronizes comparator flags,
// resolves the tolerance setting, and combines seal, cell selection and
// enable gating into the memory-side outputs.
// Assumes flags change slowly relative to clk and host_ce_n is clk-synchronous.
module nvsram_supervisor
    import nvs_pkg::*;
#(
    parameter int REC_CYCLES  = 4_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_ce_n,
    input  logic       vdd_ok_5,
    input  logic       vdd_ok_10,
    input  logic       tol_wide,
    input  logic       bat_a_ok,
    input  logic       bat_b_ok,
    input  logic       b_grounded,
    input  logic       a_ge_b,
    input  logic       vdd_gt_bat,
    output logic       mem_ce_n,
    output logic       bat_sel,
    output logic [1:0] rail_src,
    output logic [2:0] status
);
    logic [FLAG_W-1:0] raw_f, syn_f;
    logic vdd_ok, sel_bad, sealed, dark, ce_gate_n, bat_low;
    rail_t rail;

    assign raw_f[F_OK5]    = vdd_ok_5;
    assign raw_f[F_OK10]   = vdd_ok_10;
    assign raw_f[F_TOL]    = tol_wide;
    assign raw_f[F_A_OK]   = bat_a_ok;
    assign raw_f[F_B_OK]   = bat_b_ok;
    assign raw_f[F_B_GND]  = b_grounded;
    assign raw_f[F_A_GE_B] = a_ge_b;
    assign raw_f[F_GT_BAT] = vdd_gt_bat;

    nvs_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_f), .q(syn_f)
    );

    // tolerance setting picks which trip flag means supply good
    assign vdd_ok = syn_f[F_TOL] ? syn_f[F_OK10] : syn_f[F_OK5];

    nvs_bat_sel u_bsel (
        .clk(clk), .rst_n(rst_n),
        .a_ok(syn_f[F_A_OK]), .b_ok(syn_f[F_B_OK]), .b_gnd(syn_f[F_B_GND]),
        .a_ge_b(syn_f[F_A_GE_B]), .sel_b(bat_sel), .sel_bad(sel_bad)
    );

    nvs_seal u_seal (
        .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .vdd_gt_bat(syn_f[F_GT_BAT]),
        .sealed(sealed), .dark(dark)
    );

    nvs_ctrl #(.REC_CYCLES(REC_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .host_ce_n(host_ce_n),
        .sel_bad(sel_bad), .ce_gate_n(ce_gate_n), .bat_low(bat_low)
    );

    // rail source: off while dark, battery when supply is below it
    always_comb begin
        if (dark)                 rail = RAIL_OFF;
        else if (syn_f[F_GT_BAT]) rail = RAIL_VDD;
        else                      rail = RAIL_BAT;
    end

    assign rail_src = rail;
    assign mem_ce_n = dark ? 1'b0 : ce_gate_n;
    assign status   = {rail == RAIL_BAT, sealed, bat_low};

    p_dark_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dark |-> (!mem_ce_n && rail_src == 2'b10));

    p_bad_supply_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!vdd_ok && $past(!vdd_ok) && $past(mem_ce_n) && !dark) |-> mem_ce_n);
endmodule

// File: tb/sim_nvsram_supervisor.sv
module sim_nvsram_supervisor;
    localparam int REC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_ce_n = 1'b1;
    logic vdd_ok_5 = 1'b0, vdd_ok_10 = 1'b0, tol_wide = 1'b0;
    logic bat_a_ok = 1'b0, bat_b_ok = 1'b0, b_grounded = 1'b0, a_ge_b = 1'b0;
    logic vdd_gt_bat = 1'b0;
    logic mem_ce_n, bat_sel;
    logic [1:0] rail_src;
    logic [2:0] status;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nvsram_supervisor #(.REC_CYCLES(REC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n),
        .vdd_ok_5(vdd_ok_5), .vdd_ok_10(vdd_ok_10), .tol_wide(tol_wide),
        .bat_a_ok(bat_a_ok), .bat_b_ok(bat_b_ok), .b_grounded(b_grounded),
        .a_ge_b(a_ge_b), .vdd_gt_bat(vdd_gt_bat),
        .mem_ce_n(mem_ce_n), .bat_sel(bat_sel), .rail_src(rail_src), .status(status)
    );

    // vector: ok5 ok10 tol a_ok b_ok b_gnd a_ge_b gt_bat ce | exp_ce exp_sel exp_src[1:0]
    localparam int NV = 10;
    localparam logic [12:0] VEC [NV] = '{
        13'b1_1_0_1_1_0_1_1_0__0_0_00,  // R1 pass low, R5 equal good -> higher A
        13'b1_1_0_1_1_0_1_1_1__1_0_00,  // R1 pass high
        13'b1_1_0_1_1_0_0_1_0__0_1_00,  // R5 B higher
        13'b1_1_0_0_1_0_1_1_1__1_1_00,  // R5 A failed, B takes over
        13'b1_1_0_1_0_0_0_1_0__0_0_00,  // R5 B failed though higher
        13'b1_1_0_1_1_1_0_1_1__1_0_00,  // R6 grounded B ignored
        13'b0_1_1_1_1_0_1_1_0__0_0_00,  // R3 wide tolerance still good
        13'b1_1_0_0_0_0_0_1_1__1_1_00,  // R5 both bad -> higher B
        13'b1_1_0_1_1_0_1_0_0__0_0_01,  // R9 supply below battery -> battery
        13'b1_1_0_1_1_0_1_1_1__1_0_00   // R9 back to supply
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic supply(input logic good);
        vdd_ok_5 = good; vdd_ok_10 = good; tol_wide = 1'b0;
    endtask

    task automatic pulse_ce(output logic seen);
        host_ce_n = 1'b0; #1; seen = mem_ce_n;
        cyc(2); host_ce_n = 1'b1; cyc(2);
    endtask

    initial begin
        cyc(200_000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic s1, s2, s3;
        cyc(4); rst_n = 1'b1; cyc(1);
        // reset: sealed and dark
        chk("R7 reset ce", {3'b0, mem_ce_n}, 4'h0);
        chk("R7 reset rail", {2'b0, rail_src}, 4'h2);
        chk("R7 reset status", {1'b0, status}, 4'h2);

        // first power-up, cell A good, B grounded
        bat_a_ok = 1; b_grounded = 1; vdd_gt_bat = 1; host_ce_n = 0;
        supply(1);
        cyc(REC); #1;
        chk("R8 still recovering", {3'b0, mem_ce_n}, 4'h1);
        cyc(6); #1;
        chk("R1 pass after recovery", {3'b0, mem_ce_n}, 4'h0);
        chk("R6 no warning grounded B", {1'b0, status}, 4'h2);
        chk("R9 rail supply, seal kept", {2'b0, rail_src}, 4'h0);

        // table walk in powered state
        for (int i = 0; i < NV; i++) begin
            {vdd_ok_5, vdd_ok_10, tol_wide, bat_a_ok, bat_b_ok, b_grounded,
             a_ge_b, vdd_gt_bat, host_ce_n} = VEC[i][12:4];
            cyc(4); #1;
            chk($sformatf("R1 vec%0d ce", i), {3'b0, mem_ce_n}, {3'b0, VEC[i][3]});
            chk($sformatf("R5 vec%0d sel", i), {3'b0, bat_sel}, {3'b0, VEC[i][2]});
            chk($sformatf("R9 vec%0d rail", i), {2'b0, rail_src}, {2'b0, VEC[i][1:0]});
        end
        chk("R7 seal released", {1'b0, status}, 4'h0);

        // tolerance: narrow setting with only wide flag -> supply bad
        bat_a_ok = 1; bat_b_ok = 1; b_grounded = 0; a_ge_b = 1; vdd_gt_bat = 1;
        vdd_ok_5 = 0; vdd_ok_10 = 1; tol_wide = 0; host_ce_n = 1;
        cyc(5); host_ce_n = 0; #1;
        chk("R3 narrow tol blocks", {3'b0, mem_ce_n}, 4'h1);
        host_ce_n = 1; tol_wide = 1;
        cyc(REC + 6); host_ce_n = 0; #1;
        chk("R3 wide tol passes", {3'b0, mem_ce_n}, 4'h0);

        // brown-out mid access (ce low), R2
        supply(0); tol_wide = 0;
        cyc(6); #1;
        chk("R2 held during access", {3'b0, mem_ce_n}, 4'h0);
        host_ce_n = 1; #1;
        chk("R2 released high", {3'b0, mem_ce_n}, 4'h1);
        cyc(2); host_ce_n = 0; #1;
        chk("R2 inhibited afterwards", {3'b0, mem_ce_n}, 4'h1);
        host_ce_n = 1;

        // weak cell at power-up: A bad, B grounded
        bat_a_ok = 0; b_grounded = 1;
        supply(1);
        cyc(REC + 6);
        chk("R4 low latched", {3'b0, status[0]}, 4'h1);
        pulse_ce(s1); pulse_ce(s2); pulse_ce(s3);
        chk("R4 first access", {3'b0, s1}, 4'h0);
        chk("R4 second blocked", {3'b0, s2}, 4'h1);
        chk("R10 third passes", {3'b0, s3}, 4'h0);
        pulse_ce(s1);
        chk("R10 fourth passes", {3'b0, s1}, 4'h0);
        bat_a_ok = 1; cyc(4);
        chk("R4 no clear without power-up", {3'b0, status[0]}, 4'h1);

        // redundant power-up: A bad, B good
        supply(0); cyc(6);
        bat_a_ok = 0; bat_b_ok = 1; b_grounded = 0; a_ge_b = 1;
        supply(1); cyc(REC + 6);
        chk("R5 B selected", {3'b0, bat_sel}, 4'h1);
        chk("R4 cleared by good cell", {3'b0, status[0]}, 4'h0);
        pulse_ce(s1); pulse_ce(s2);
        chk("R4 second passes when good", {3'b0, s2}, 4'h0);

        // supply below battery: backup rail, seal not re-entered
        vdd_gt_bat = 0; supply(0); cyc(6);
        chk("R9 on battery status", {1'b0, status}, 4'h4);
        chk("R7 no re-seal", {2'b0, rail_src}, 4'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule